// File: doc/BRIEF.md
# CPU-Resident Six-Line Parallel Port

This block is the small bidirectional port that sits inside a processor and occupies the two lowest locations of its address space. Address 0 holds a per-line direction register. Address 1 holds a per-line data register. Each of the six lines goes to a pin with an external pull-up. A line whose direction bit is set drives its data bit onto the pin. A line whose direction bit is clear is left floating, so its pin level comes from outside.

The block also presents the resolved level of every line. Downstream memory-banking logic uses these levels. Lines 0 to 2 select the low-ROM, high-ROM and character-ROM/I-O banking. Line 3 is cassette write data, line 4 is the cassette sense input, and line 5 is the active-low cassette motor control. After reset every line is an input, so the pull-ups make the banking controls read 1.

A bus decoder sorts each cycle into one of three access kinds: `ACC_NONE` (address is neither 0 nor 1), `ACC_DIR` (address 0) and `ACC_DATA` (address 1). The decoder is purely combinational and keeps no state, so a cycle moves to any kind from any kind. The kind selects which register a write strobe updates and which value the read bus returns. The block also raises a claim flag for these two addresses, so the surrounding memory system does not treat those accesses as RAM accesses.

Top module: `cpu_ioport`

## Requirements
- R1: While reset is asserted and after it is released, both registers hold 0. As a result every `pin_oe` bit is 0 and a read of address 0 returns 0x00.
- R2: A cycle with `bus_we` high and `bus_addr` = 0 loads `bus_wdata[5:0]` into the direction register at that clock edge. A later read of address 0 returns the stored value.
- R3: A cycle with `bus_we` high and `bus_addr` = 1 loads `bus_wdata[5:0]` into the data register at that clock edge.
- R4: `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals data bit i.
- R5: `line_level[i]` equals data bit i when direction bit i is 1. It equals `pin_in[i]` when direction bit i is 0.
- R6: A read of address 1 returns, in bits 5:0, the data register bit for each output line and the `pin_in` bit for each input line.
- R7: Bits 7:6 of `rd_data` read 0 at both addresses. Values written to bits 7:6 are discarded.
- R8: `port_hit` is 1 exactly when `bus_addr` is 0 or 1. A write to any other address leaves both registers unchanged.
- R9: After direction 0x2F and data 0x37 are written, lines 0 to 2 read 1 as levels, line 5 is 1, line 3 is 0, and line 4 follows `pin_in[4]`.
- R10: Right after reset, with pins pulled high (`pin_in` = all ones), every `line_level` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (0 when not claimed) |
| port_hit | output | 1 | Access claimed by the port |
| pin_in | input | 6 | Sensed pin levels, pulled high when undriven |
| pin_oe | output | 6 | Per-line output enable |
| pin_out | output | 6 | Per-line driven value |
| line_level | output | 6 | Resolved level seen by banking logic |

## Verification
The assertions check the following on every cycle:
- a write to address 0 or address 1 lands in the matching register on the next edge (R2, R3);
- both registers stay unchanged on cycles with no claimed write (R8);
- the registers are cleared while reset is held (R1);
- the two upper read bits stay 0 (R7).

Some behaviour only the bench scenarios can show. These are the line-by-line mixing of register bits and pin inputs in `line_level` and in the read of address 1 (R5, R6), and the pull-up default after reset (R10). The bench covers them by sweeping all 64 direction values against several data and pin patterns, and by reproducing the normal banking setting (R9).

// File: rtl/cpu_ioport_pkg.sv
package cpu_ioport_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DIR  = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/cpu_ioport_decode.sv
module cpu_ioport_decode
    import cpu_ioport_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    output acc_kind_e     kind,
    output logic          hit
);
    always_comb begin
        kind = ACC_NONE;
        if (addr[AW-1:1] == '0) begin
            kind = addr[0] ? ACC_DATA : ACC_DIR;
        end
    end

    assign hit = (kind != ACC_NONE);
endmodule

// File: rtl/cpu_ioport_regs.sv
module cpu_ioport_regs
    import cpu_ioport_pkg::*;
#(
    parameter int NL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_kind_e     kind,
    input  logic          we,
    input  logic [NL-1:0] wdata,
    output logic [NL-1:0] dir_q,
    output logic [NL-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (we) begin
            unique case (kind)
                ACC_DIR:  dir_q  <= wdata;
                ACC_DATA: data_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Write to the direction register lands on the next edge.
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == ACC_DIR) |=> (dir_q == $past(wdata)));

    // Write to the data register lands on the next edge.
    assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == ACC_DATA) |=> (data_q == $past(wdata)));

    // No claimed write: both registers hold their values.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && kind != ACC_NONE) |=> ($stable(dir_q) && $stable(data_q)));

    // Registers read as zero while reset is held.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (dir_q == '0 && data_q == '0));
endmodule

// File: rtl/cpu_ioport_lines.sv
module cpu_ioport_lines #(
    parameter int NL = 6
) (
    input  logic [NL-1:0] dir_q,
    input  logic [NL-1:0] data_q,
    input  logic [NL-1:0] pin_in,
    output logic [NL-1:0] pin_oe,
    output logic [NL-1:0] pin_out,
    output logic [NL-1:0] level
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        assign pin_oe[i]  = dir_q[i];
        assign pin_out[i] = data_q[i];
        assign level[i]   = dir_q[i] ? data_q[i] : pin_in[i];
    end
endmodule

// File: rtl/cpu_ioport.sv
module cpu_ioport
    import cpu_ioport_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int NL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    output logic          port_hit,
    input  logic [NL-1:0] pin_in,
    output logic [NL-1:0] pin_oe,
    output logic [NL-1:0] pin_out,
    output logic [NL-1:0] line_level
);
    localparam int PADW = DW - NL;

    acc_kind_e     kind;
    logic [NL-1:0] dir_q;
    logic [NL-1:0] data_q;
    logic          unused_wbits;

    assign unused_wbits = ^bus_wdata[DW-1:NL];

    cpu_ioport_decode #(.AW(AW)) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .hit  (port_hit)
    );

    cpu_ioport_regs #(.NL(NL)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .we     (bus_we),
        .wdata  (bus_wdata[NL-1:0]),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    cpu_ioport_lines #(.NL(NL)) u_lines (
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pin_in  (pin_in),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .level   (line_level)
    );

    always_comb begin
        rd_data = '0;
        unique case (kind)
            ACC_DIR:  rd_data = {{PADW{1'b0}}, dir_q};
            ACC_DATA: rd_data = {{PADW{1'b0}}, line_level};
            default:  rd_data = '0;
        endcase
    end

    // Upper read bits never carry data.
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:NL] == '0);
endmodule

// File: tb/cpu_ioport_bench.sv
module cpu_ioport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        port_hit;
    logic [5:0]  pin_in = 6'h3F;
    logic [5:0]  pin_oe, pin_out, line_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cpu_ioport u_cpu_ioport (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .port_hit(port_hit),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .line_level(line_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5:0] pats [4];
        pats[0] = 6'h00; pats[1] = 6'h3F; pats[2] = 6'h15; pats[3] = 6'h2A;

        // R1 during reset
        #5;
        chk(pin_oe == 6'h00, "R1 oe in reset", pin_oe, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(16'h0000, v);
        chk(v == 8'h00, "R1 dir after reset", v, 0);
        chk(pin_oe == 6'h00, "R1 oe after reset", pin_oe, 0);
        chk(pin_out == 6'h00, "R1 data after reset", pin_out, 0);
        // R10 pull-ups
        chk(line_level == 6'h3F, "R10 pulled-up levels", line_level, 6'h3F);
        rd(16'h0001, v);
        chk(v == 8'h3F, "R10 read pulled-up", v, 8'h3F);

        // R8 claim flag
        rd(16'h0002, v);
        chk(port_hit == 1'b0 && v == 8'h00, "R8 addr2 not claimed", port_hit, 0);
        rd(16'hFFFE, v);
        chk(port_hit == 1'b0, "R8 high addr not claimed", port_hit, 0);
        rd(16'h0100, v);
        chk(port_hit == 1'b0, "R8 addr 0x100 not claimed", port_hit, 0);
        rd(16'h0001, v);
        chk(port_hit == 1'b1, "R8 addr1 claimed", port_hit, 1);
        rd(16'h0000, v);
        chk(port_hit == 1'b1, "R8 addr0 claimed", port_hit, 1);
        // R8 stray writes ignored
        wr(16'h0002, 8'hFF);
        wr(16'h8000, 8'hFF);
        wr(16'h0101, 8'hFF);
        chk(pin_oe == 6'h00 && pin_out == 6'h00, "R8 stray write ignored",
            {pin_oe, pin_out}, 0);

        // Exhaustive sweep: R2 R3 R4 R5 R6 R7
        for (int d = 0; d < 64; d++) begin
            wr(16'h0000, {2'b11, d[5:0]});
            rd(16'h0000, v);
            chk(v == {2'b00, d[5:0]}, "R2 R7 dir readback", v, d);
            chk(pin_oe == d[5:0], "R4 oe follows dir", pin_oe, d);
            for (int k = 0; k < 4; k++) begin
                logic [5:0] dat;
                dat = pats[k];
                wr(16'h0001, {2'b10, dat});
                chk(pin_out == dat, "R3 R4 data to pin_out", pin_out, dat);
                for (int p = 0; p < 4; p++) begin
                    logic [5:0] exp_lv;
                    pin_in = pats[p];
                    exp_lv = (d[5:0] & dat) | (~d[5:0] & pats[p]);
                    rd(16'h0001, v);
                    chk(line_level == exp_lv, "R5 resolved level", line_level, exp_lv);
                    chk(v == {2'b00, exp_lv}, "R6 R7 data read", v, exp_lv);
                end
            end
        end

        // R9 normal banking setting
        pin_in = 6'h3F;
        wr(16'h0001, 8'h37);
        wr(16'h0000, 8'h2F);
        chk(line_level[2:0] == 3'b111, "R9 banking lines high", line_level[2:0], 7);
        chk(line_level[5] == 1'b1 && line_level[3] == 1'b0, "R9 cassette lines",
            {line_level[5], line_level[3]}, 2);
        pin_in = 6'h2F;
        #1;
        chk(line_level[4] == 1'b0, "R9 sense follows pin", line_level[4], 0);
        pin_in = 6'h3F;
        #1;
        chk(line_level[4] == 1'b1, "R9 sense follows pin high", line_level[4], 1);
        // Banking line switched to input floats high
        wr(16'h0001, 8'h30);
        wr(16'h0000, 8'h2E);
        chk(line_level[0] == 1'b1 && line_level[1] == 1'b0,
            "R5 input banking line reads pulled-up", line_level[1:0], 1);

        // R1 reset again clears state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(pin_oe == 6'h00 && pin_out == 6'h00, "R1 reset clears",
            {pin_oe, pin_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule